// File: doc/BRIEF.md
# SONET A1/A2 Frame Aligner

This block takes the byte-aligned stream recovered from one serial link and finds where each SONET frame begins. It looks for the framing pattern made of A1 bytes followed by A2 bytes. The length of each run depends on how many STS-1 signals are byte-interleaved on the link. A mode input selects one of two interleave factors: N = 3 or N = 12. After the first pattern is seen, the block tracks the position of every byte in the 9-row frame. It flags the transport-overhead bytes so that later logic can pass them through or replace them. It also emits a pulse at the start of each frame.

A frame counts as found only after the pattern appears twice in a row at the expected place. From then on, the block tolerates isolated damaged patterns. When patterns are missing repeatedly, it reports loss of frame and starts searching again. Bit alignment, descrambling, pointer handling and overhead insertion belong to other blocks.

Top module: `sonet_framer`

## Requirements
- R1: While reset is high and right after it, in_frame, lof, frame_start and toh_flag are 0, and row and col are 0.
- R2: The framing pattern is N consecutive bytes 0xF6 followed by N consecutive bytes 0x28, counted over valid bytes only. N = 3 when sts12_sel = 0 and N = 12 when sts12_sel = 1. A run with fewer than N bytes of 0xF6 is not a pattern.
- R3: The first pattern starts tracking. in_frame rises in the cycle after the last 0x28 byte of the second pattern, where that pattern sits exactly 810·N valid bytes after the first.
- R4: While tracking but not yet in frame, a missing pattern at the expected place ends tracking. Two new patterns are then needed before in_frame rises.
- R5: While in frame, up to 3 consecutive missing patterns leave in_frame at 1.
- R6: The 4th consecutive missing pattern raises lof for exactly one cycle, in the cycle after that frame's last framing-byte position. in_frame falls in that same cycle, and the search restarts.
- R7: While tracking, frame_start is 1 exactly when a valid byte sits at row 0, col 2·N, which is the first byte after the last 0x28.
- R8: While tracking, row and col give the position of the byte currently on in_byte. col counts 0 to 90·N−1 and advances on each valid byte. row counts 0 to 8 and advances when col wraps.
- R9: toh_flag is 1 while tracking when col < 3·N, and 0 otherwise.
- R10: A byte with in_valid = 0 changes nothing: row and col hold, frame_start stays 0, and it is never taken as a framing byte.
- R11: A change of sts12_sel drops in_frame in the next cycle and restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte carries a byte this cycle |
| in_byte | input | 8 | Byte-aligned receive data |
| sts12_sel | input | 1 | 0: N = 3, 1: N = 12 |
| frame_start | output | 1 | First byte after the framing pattern |
| row | output | 4 | Row of the current byte (0..8) |
| col | output | 11 | Column of the current byte (0..90·N−1) |
| toh_flag | output | 1 | Current byte lies in transport overhead |
| in_frame | output | 1 | Frame alignment confirmed |
| lof | output | 1 | One-cycle loss-of-frame pulse |

## Verification
The stream is a sequence of complete frames with payload that never contains a framing byte. Individual frames have their first A1 byte replaced, which shortens the A1 run by one. Runs of such damaged frames of length 1, 3 and 4 separate confirmation failure, tolerated misses and loss of frame. In the N = 12 mode, one shortened frame shows that a run of N−1 A1 bytes is rejected. Once lock is reached, every byte of whole frames is compared against the row, column, overhead and frame-start values computed from the byte index. Stray 0xF6 bytes are driven during idle cycles to show that invalid cycles are neither counted nor matched.

// File: rtl/sonet_fr_pkg.sv
package sonet_fr_pkg;

    localparam logic [7:0] A1_BYTE = 8'hF6;
    localparam logic [7:0] A2_BYTE = 8'h28;
    localparam int ROWS      = 9;
    localparam int COLS_STS1 = 90;
    localparam int TOH_STS1  = 3;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic [15:0] row_len;   // bytes per row
        logic [15:0] last_a2;   // column of last framing byte
        logic [15:0] fs_col;    // column of first byte after framing
        logic [15:0] toh_len;   // overhead columns per row
    } geom_t;

    function automatic geom_t geom_of(input int n);
        geom_t g;
        g.row_len = 16'(COLS_STS1 * n);
        g.last_a2 = 16'(2 * n - 1);
        g.fs_col  = 16'(2 * n);
        g.toh_len = 16'(TOH_STS1 * n);
        return g;
    endfunction

endpackage

// File: rtl/sonet_a1a2_det.sv
module sonet_a1a2_det
    import sonet_fr_pkg::*;
#(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [7:0]    data,
    input  logic [NW-1:0] n,
    output logic          match
);
    logic [NW-1:0] a1_cnt;
    logic [NW-1:0] a2_cnt;
    logic          is_a1, is_a2, armed;

    always_comb begin
        is_a1 = (data == A1_BYTE);
        is_a2 = (data == A2_BYTE);
        armed = (a2_cnt != '0) || (a1_cnt >= n);
        match = valid && is_a2 && armed && (a2_cnt == n - NW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a1_cnt <= '0;
            a2_cnt <= '0;
        end else if (valid) begin
            if (is_a1) begin
                a1_cnt <= (a1_cnt >= n) ? a1_cnt : a1_cnt + NW'(1);
                a2_cnt <= '0;
            end else if (is_a2 && armed && !match) begin
                a1_cnt <= '0;
                a2_cnt <= a2_cnt + NW'(1);
            end else begin
                a1_cnt <= '0;
                a2_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/sonet_pos_cnt.sv
module sonet_pos_cnt
    import sonet_fr_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             load,
    input  logic [COL_W-1:0] load_col,
    input  logic [COL_W-1:0] col_end,
    output logic [3:0]       row,
    output logic [COL_W-1:0] col
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            col <= '0;
        end else if (adv) begin
            if (load) begin
                row <= '0;
                col <= load_col;
            end else if (col >= col_end) begin
                col <= '0;
                row <= (row >= 4'(ROWS - 1)) ? 4'd0 : row + 4'd1;
            end else begin
                col <= col + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/sonet_sync_fsm.sv
module sonet_sync_fsm
    import sonet_fr_pkg::*;
#(
    parameter int CONFIRM  = 2,
    parameter int MISS_LIM = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic mode,
    input  logic match,
    input  logic at_check,
    output logic load,
    output logic tracking,
    output logic locked,
    output logic lof
);
    localparam int HW = $clog2(CONFIRM + 1);
    localparam int MW = $clog2(MISS_LIM + 1);

    sync_state_e   state;
    logic [HW-1:0] hits;
    logic [MW-1:0] misses;
    logic          mode_q;
    logic          mode_chg;

    always_comb begin
        mode_chg = (mode != mode_q);
        load     = valid && !mode_chg && (state == ST_HUNT) && match;
        tracking = (state != ST_HUNT);
        locked   = (state == ST_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_HUNT;
            hits   <= '0;
            misses <= '0;
            mode_q <= 1'b0;
            lof    <= 1'b0;
        end else begin
            lof    <= 1'b0;
            mode_q <= mode;
            if (mode_chg) begin
                state  <= ST_HUNT;
                hits   <= '0;
                misses <= '0;
            end else if (valid) begin
                case (state)
                    ST_HUNT: if (match) begin
                        state  <= ST_CONFIRM;
                        hits   <= HW'(1);
                        misses <= '0;
                    end
                    ST_CONFIRM: if (at_check) begin
                        if (!match)                       state <= ST_HUNT;
                        else if (hits == HW'(CONFIRM - 1)) state <= ST_LOCKED;
                        else                              hits  <= hits + HW'(1);
                    end
                    ST_LOCKED: if (at_check) begin
                        if (match) begin
                            misses <= '0;
                        end else if (misses == MW'(MISS_LIM - 1)) begin
                            state  <= ST_HUNT;
                            misses <= '0;
                            lof    <= 1'b1;
                        end else begin
                            misses <= misses + MW'(1);
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/sonet_framer.sv
module sonet_framer
    import sonet_fr_pkg::*;
#(
    parameter int N_LO     = 3,
    parameter int N_HI     = 12,
    parameter int CONFIRM  = 2,
    parameter int MISS_LIM = 4,
    localparam int COL_W   = $clog2(COLS_STS1 * N_HI)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             sts12_sel,
    output logic             frame_start,
    output logic [3:0]       row,
    output logic [COL_W-1:0] col,
    output logic             toh_flag,
    output logic             in_frame,
    output logic             lof
);
    localparam int NW = $clog2(N_HI + 1);

    geom_t         g;
    logic [NW-1:0] n_cur;
    logic          match, at_check, load, tracking;

    always_comb begin
        g        = sts12_sel ? geom_of(N_HI) : geom_of(N_LO);
        n_cur    = sts12_sel ? NW'(N_HI) : NW'(N_LO);
        at_check = (row == 4'd0) && (16'(col) == g.last_a2);
        frame_start = in_valid && tracking && (row == 4'd0) && (16'(col) == g.fs_col);
        toh_flag = tracking && (16'(col) < g.toh_len);
    end

    sonet_a1a2_det #(.NW(NW)) u_det (
        .clk(clk), .rst(rst), .valid(in_valid), .data(in_byte),
        .n(n_cur), .match(match)
    );

    sonet_pos_cnt #(.COL_W(COL_W)) u_pos (
        .clk(clk), .rst(rst), .adv(in_valid), .load(load),
        .load_col(COL_W'(g.fs_col)), .col_end(COL_W'(g.row_len - 16'd1)),
        .row(row), .col(col)
    );

    sonet_sync_fsm #(.CONFIRM(CONFIRM), .MISS_LIM(MISS_LIM)) u_fsm (
        .clk(clk), .rst(rst), .valid(in_valid), .mode(sts12_sel),
        .match(match), .at_check(at_check), .load(load),
        .tracking(tracking), .locked(in_frame), .lof(lof)
    );
endmodule

// File: rtl/sonet_framer_chk.sv
module sonet_framer_chk #(
    parameter int N_LO  = 3,
    parameter int N_HI  = 12,
    parameter int COL_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             sts12_sel,
    input logic             frame_start,
    input logic [3:0]       row,
    input logic [COL_W-1:0] col,
    input logic             toh_flag,
    input logic             in_frame,
    input logic             lof
);
    logic [15:0] row_len;
    assign row_len = sts12_sel ? 16'(90 * N_HI) : 16'(90 * N_LO);

    // R7
    fs_toh_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (toh_flag && row == 4'd0 && in_valid));

    // R6
    lof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lof |=> !lof);

    // R6
    lof_drop_chk: assert property (@(posedge clk) disable iff (rst)
        lof |-> (!in_frame && $past(in_frame)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(row) && $stable(col)));

    // R8
    row_rng_chk: assert property (@(posedge clk) disable iff (rst)
        row < 4'd9);

    // R8
    col_rng_chk: assert property (@(posedge clk) disable iff (rst)
        in_frame |-> (16'(col) < row_len));

    // R11
    mode_chk: assert property (@(posedge clk) disable iff (rst)
        (sts12_sel != $past(sts12_sel)) |=> !in_frame);

    // R3
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> $past(in_valid));
endmodule

bind sonet_framer sonet_framer_chk #(.N_LO(N_LO), .N_HI(N_HI), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sts12_sel(sts12_sel),
    .frame_start(frame_start), .row(row), .col(col), .toh_flag(toh_flag),
    .in_frame(in_frame), .lof(lof)
);

// File: tb/sonet_framer_test.sv
module sonet_framer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        sts12_sel;
    logic        frame_start, toh_flag, in_frame, lof;
    logic [3:0]  row;
    logic [10:0] col;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sonet_framer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .sts12_sel(sts12_sel), .frame_start(frame_start), .row(row),
        .col(col), .toh_flag(toh_flag), .in_frame(in_frame), .lof(lof)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int n = 3;
    int gpos = 0;
    int fidx = 0;
    logic [31:0] bad = '0;
    bit geo = 0;
    bit gaps = 0;
    int lof_count = 0;
    int s_row, s_col;
    bit s_toh, s_fs, s_if, s_lof;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (frame %0d pos %0d)", req, act, exp, fidx, gpos);
        end
    endtask

    function automatic logic [7:0] byte_at(input int nn, input int pos, input int f);
        int r, c;
        logic [7:0] v;
        r = pos / (90 * nn);
        c = pos % (90 * nn);
        if (r == 0 && c < nn) return (bad[f] && c == 0) ? 8'h5A : 8'hF6;
        if (r == 0 && c < 2 * nn) return 8'h28;
        v = 8'(pos * 37 + f * 11 + 7);
        if (v == 8'hF6 || v == 8'h28) v = v ^ 8'h01;
        return v;
    endfunction

    task automatic send1(input bit v);
        int er, ec;
        @(negedge clk);
        in_valid = v;
        in_byte  = v ? byte_at(n, gpos, fidx) : 8'hF6;
        #1;
        s_row = int'(row); s_col = int'(col); s_toh = toh_flag; s_fs = frame_start;
        if (geo) begin
            er = gpos / (90 * n);
            ec = gpos % (90 * n);
            chk(s_row == er, "R8 row", s_row, er);
            chk(s_col == ec, "R8 col", s_col, ec);
            chk(s_toh == (ec < 3 * n), "R9 toh_flag", s_toh, int'(ec < 3 * n));
            chk(s_fs == (v && er == 0 && ec == 2 * n), v ? "R7 frame_start" : "R10 frame_start idle",
                s_fs, int'(v && er == 0 && ec == 2 * n));
        end
        @(posedge clk);
        #1;
        s_if = in_frame; s_lof = lof;
        if (s_lof) lof_count++;
        if (geo) chk(s_if == 1'b1, "R5 in_frame held", s_if, 1);
        if (v) begin
            gpos++;
            if (gpos == 810 * n) begin
                gpos = 0;
                fidx++;
            end
        end
    endtask

    task automatic send_until(input int tf, input int tp);
        while (!(fidx == tf && gpos == tp)) begin
            if (gaps && (gpos % 617) == 300) send1(1'b0);
            send1(1'b1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; sts12_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(in_frame == 0, "R1 in_frame", int'(in_frame), 0);
        chk(lof == 0, "R1 lof", int'(lof), 0);
        chk(frame_start == 0, "R1 frame_start", int'(frame_start), 0);
        chk(toh_flag == 0, "R1 toh_flag", int'(toh_flag), 0);
        chk(row == 0 && col == 0, "R1 row/col", int'(col), 0);

        // N = 3, start mid-frame
        n = 3; gpos = 1000; fidx = 0;
        bad = (32'h1 << 4) | (32'h1 << 5) | (32'h1 << 6) | (32'h1 << 8) | (32'h1 << 9)
            | (32'h1 << 10) | (32'h1 << 11) | (32'h1 << 13) | (32'h1 << 21);
        send_until(1, 2 * n);
        chk(s_if == 0, "R3 one pattern not enough", s_if, 0);
        send_until(2, 2 * n);
        chk(s_if == 1, "R3 lock after two patterns", s_if, 1);

        // full-frame geometry sweep with idle gaps, then 3 tolerated misses (R5)
        geo = 1; gaps = 1;
        send_until(11, 2 * n - 1);
        geo = 0; gaps = 0;
        chk(lof_count == 0, "R5 no lof on 3 misses", lof_count, 0);
        send1(1'b1);
        chk(s_lof == 1, "R6 lof on 4th miss", s_lof, 1);
        chk(s_if == 0, "R6 in_frame drops", s_if, 1'b0);
        send1(1'b1);
        chk(s_lof == 0, "R6 lof one cycle", s_lof, 0);

        // confirmation failure
        send_until(12, 2 * n);
        chk(s_if == 0, "R4 tracking not locked", s_if, 0);
        send_until(13, 2 * n);
        chk(s_if == 0, "R4 miss during confirm", s_if, 0);
        send_until(14, 2 * n);
        chk(s_if == 0, "R4 needs two fresh patterns", s_if, 0);
        send_until(15, 2 * n);
        chk(s_if == 1, "R4 relock", s_if, 1);
        chk(lof_count == 1, "R6 single lof pulse", lof_count, 1);

        // mode change to N = 12
        n = 12; sts12_sel = 1'b1; gpos = 500; fidx = 20;
        send1(1'b1);
        chk(s_if == 0, "R11 mode change drops lock", s_if, 0);
        chk(s_lof == 0, "R11 no lof on mode change", s_lof, 0);
        send_until(21, 2 * n);
        chk(s_if == 0, "R2 short A1 run rejected", s_if, 0);
        send_until(22, 2 * n);
        chk(s_if == 0, "R2 first N=12 pattern", s_if, 0);
        send_until(23, 2 * n);
        chk(s_if == 1, "R2 R3 lock in N=12", s_if, 1);
        geo = 1; gaps = 1;
        send_until(24, 2 * n);
        geo = 0; gaps = 0;
        chk(lof_count == 1, "R5 no further lof", lof_count, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule